// File: doc/BRIEF.md
# Interrupt-Paced Manchester Byte Transmitter

This block sends bytes over a single serial line in Manchester form. The host writes a byte into a one-byte pending register through a simple write strobe. The block cuts time into frames of eight bit periods, and a transmit interrupt marks the start of each frame. At each frame start the pending byte, if one was written, moves into the serialiser. It then goes out most significant bit first, with every bit split into two complementary halves.

The frame rate depends on a mode input. With the default parameters at 50 MHz, mode 0 gives 10 kbit/s (a frame every 800 µs) and mode 1 gives 8 kbit/s (a frame every 1000 µs). Each mode's number of clock cycles per half-bit is a parameter. The interrupt keeps arriving at this rate even when the line output is disabled. Software can therefore pace its writes on the interrupt alone. A sticky flag keeps a record of the interrupt until the host clears it.

Top module: `man_byte_tx`

## Requirements
- R1: A byte written with `wr_i` is transmitted in the frame that begins at the next interrupt boundary after the write clock edge.
- R2: Bits leave most significant first. Bit 7 occupies half-bits 0 and 1 of the frame, and bit 0 occupies half-bits 14 and 15.
- R3: Encoding: a 1 is sent as high in the first half and low in the second half. A 0 is sent as low then high. Each half lasts exactly HALF_FAST clock cycles (mode 0) or HALF_SLOW clock cycles (mode 1).
- R4: `irq_o` pulses once every 16 half-bit periods of the selected mode (mode_i = 0: HALF_FAST, mode_i = 1: HALF_SLOW).
- R5: The interrupt period stays the same while `tx_en_i` is low.
- R6: While `tx_en_i` is low, `tx_line_o` is 0 from the next clock on. A byte that is pending at an interrupt boundary while the enable is low is discarded and never sent.
- R7: In a frame with no byte written since the previous boundary, the line stays at 0 and the earlier byte is not repeated.
- R8: A write made while a frame is running is held and sent at the following boundary. When several writes land in one frame, the last one wins. A write on the boundary clock edge itself is held for the boundary after that.
- R9: `irq_o` is high for exactly one clock per boundary.
- R10: `irq_flag_o` is set together with `irq_o` and stays high until `flag_clr_i` is seen. If a set and a clear happen on the same edge, the set wins.
- R11: While reset is asserted, `tx_line_o`, `irq_o` and `irq_flag_o` are 0 and no byte is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Rate select: 0 fast, 1 slow |
| tx_en_i | input | 1 | Line output enable |
| wr_i | input | 1 | Write strobe for the pending byte |
| wdata_i | input | 8 | Byte to transmit |
| flag_clr_i | input | 1 | Clears the sticky interrupt flag |
| tx_line_o | output | 1 | Manchester serial line, idle 0 |
| irq_o | output | 1 | One-clock transmit interrupt pulse |
| irq_flag_o | output | 1 | Sticky interrupt flag |

## Verification
The edge that closes a frame does three things at once: it registers `irq_o` and the flag, it loads the byte, and it drives the first half-bit onto the line. So the bench uses the first falling edge with `irq_o` high as its time origin. From there it samples half-bit h at the middle of that half, h·HALF + HALF/2 cycles later. It expects `irq_o` low one cycle after the origin and high again exactly 16·HALF cycles after it. A flag clear is checked one cycle after the strobe. Writes, clears, enable changes and mode changes are driven on falling edges, so the model always knows which boundary each of them falls before. That includes writes and clears placed on the boundary cycle itself.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int BYTE_W = 8;
  localparam int HIDX_W = 4;
  localparam int HALVES = 2 * BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [HIDX_W-1:0] hidx_t;
endpackage

// File: rtl/mtx_pace.sv
module mtx_pace
  import mtx_pkg::*;
#(
  parameter int HALF_FAST = 2500,
  parameter int HALF_SLOW = 3125,
  parameter int CW        = 12
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  mode_i,
  output logic  tick_o,
  output hidx_t hidx_o,
  output logic  frm_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;

  assign lim_m1 = mode_i ? CW'(HALF_SLOW - 1) : CW'(HALF_FAST - 1);
  assign tick_o = (cnt_q >= lim_m1);
  assign frm_o  = tick_o && (hidx_o == hidx_t'(HALVES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hidx_o <= '0;
    end else if (tick_o) begin
      cnt_q  <= '0;
      hidx_o <= hidx_o + 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R4: a frame boundary restarts the half-bit index
  a_r4_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    frm_o |=> (hidx_o == '0));
endmodule

// File: rtl/mtx_hold.sv
module mtx_hold
  import mtx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_i,
  input  byte_t wdata_i,
  input  logic  frm_i,
  output byte_t pend_o,
  output logic  pend_v_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o   <= '0;
      pend_v_o <= 1'b0;
    end else if (wr_i) begin
      pend_o   <= wdata_i;
      pend_v_o <= 1'b1;
    end else if (frm_i) begin
      pend_v_o <= 1'b0;
    end
  end

  // R8: a held byte survives until a boundary or a newer write
  a_r8_held: assert property (@(posedge clk) disable iff (rst)
    (pend_v_o && !wr_i && !frm_i) |=> (pend_v_o && $stable(pend_o)));
endmodule

// File: rtl/mtx_serial.sv
module mtx_serial
  import mtx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en_i,
  input  logic  tick_i,
  input  logic  frm_i,
  input  hidx_t hidx_i,
  input  byte_t pend_i,
  input  logic  pend_v_i,
  output logic  line_o
);
  byte_t cur_q;
  logic  active_q;
  hidx_t nidx;
  logic  nbit;

  assign nidx = hidx_i + 1'b1;
  assign nbit = cur_q[3'd7 - nidx[3:1]];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      active_q <= 1'b0;
      line_o   <= 1'b0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      line_o   <= 1'b0;
    end else if (frm_i) begin
      if (pend_v_i) begin
        cur_q    <= pend_i;
        active_q <= 1'b1;
        line_o   <= pend_i[BYTE_W-1];
      end else begin
        active_q <= 1'b0;
        line_o   <= 1'b0;
      end
    end else if (tick_i) begin
      line_o <= active_q ? (nidx[0] ? ~nbit : nbit) : 1'b0;
    end
  end

  // R3: the line only moves on half-bit ticks while enabled
  a_r3_half_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && en_i) |=> $stable(line_o));
  // R6: a disabled output drops to idle
  a_r6_gate_idle: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !line_o);
endmodule

// File: rtl/man_byte_tx.sv
module man_byte_tx
  import mtx_pkg::*;
#(
  parameter int HALF_FAST = 2500,
  parameter int HALF_SLOW = 3125
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_i,
  input  logic       tx_en_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       flag_clr_i,
  output logic       tx_line_o,
  output logic       irq_o,
  output logic       irq_flag_o
);
  localparam int HMAX = (HALF_FAST > HALF_SLOW) ? HALF_FAST : HALF_SLOW;
  localparam int CW   = $clog2(HMAX + 1);

  logic  tick, frm, pend_v;
  hidx_t hidx;
  byte_t pend;

  mtx_pace #(.HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW), .CW(CW)) u_pace (
    .clk(clk), .rst(rst), .mode_i(mode_i),
    .tick_o(tick), .hidx_o(hidx), .frm_o(frm)
  );

  mtx_hold u_hold (
    .clk(clk), .rst(rst), .wr_i(wr_i), .wdata_i(wdata_i),
    .frm_i(frm), .pend_o(pend), .pend_v_o(pend_v)
  );

  mtx_serial u_serial (
    .clk(clk), .rst(rst), .en_i(tx_en_i), .tick_i(tick), .frm_i(frm),
    .hidx_i(hidx), .pend_i(pend), .pend_v_i(pend_v), .line_o(tx_line_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= 1'b0;
      irq_flag_o <= 1'b0;
    end else begin
      irq_o <= frm;
      if (frm)             irq_flag_o <= 1'b1;
      else if (flag_clr_i) irq_flag_o <= 1'b0;
    end
  end

  // R9: single-clock interrupt pulse
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  // R10: flag accompanies every pulse
  a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> irq_flag_o);
  // R10: a clear without a concurrent boundary empties the flag
  a_r10_flag_clr: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_i && !frm) |=> !irq_flag_o);
endmodule

// File: tb/man_byte_tx_tb.sv
module man_byte_tx_tb;
  localparam int HF = 3;
  localparam int HS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_i = 1'b0, tx_en_i = 1'b1, wr_i = 1'b0, flag_clr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic tx_line_o, irq_o, irq_flag_o;

  int checks = 0, fails = 0;
  bit done = 0;

  man_byte_tx #(.HALF_FAST(HF), .HALF_SLOW(HS)) u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .tx_en_i(tx_en_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .flag_clr_i(flag_clr_i),
    .tx_line_o(tx_line_o), .irq_o(irq_o), .irq_flag_o(irq_flag_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_half(input logic [7:0] b, input int h);
    logic bv;
    bv = b[7 - h / 2];
    return (h % 2 == 0) ? bv : ~bv;
  endfunction

  task automatic wait_irq();
    int n = 0;
    while (!irq_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pm, pb, late_b;
    bit pv, late_v, en_cur, multi, late_src;
    void'($urandom(32'h5eed_1234));
    pm = '0; pv = 0; late_v = 0; late_b = '0; en_cur = 1; multi = 0; late_src = 0;

    repeat (4) @(negedge clk);
    // R11: reset state
    chk(tx_line_o == 0, "R11 line", tx_line_o, 0);
    chk(irq_o == 0, "R11 irq", irq_o, 0);
    chk(irq_flag_o == 0, "R11 flag", irq_flag_o, 0);
    rst = 1'b0;
    wr_i = 1'b1; wdata_i = 8'hA5; pm = 8'hA5; pv = 1;
    @(negedge clk);
    wr_i = 1'b0;
    wait_irq();

    for (int f = 0; f < 30; f++) begin
      bit loaded, active, en_new, mode_new, doclr, setwin, src_multi;
      int lim, len, nw, w1, w2, lt;
      string tag;
      chk(irq_flag_o == 1, "R10 set", irq_flag_o, 1);
      loaded = pv && en_cur;
      pb = pm;
      src_multi = multi || late_src;
      pv = 0; multi = 0; late_src = 0;
      if (late_v) begin pm = late_b; pv = 1; late_v = 0; late_src = 1; end

      en_new = !(f >= 8 && f <= 10);
      mode_new = (f >= 20);
      tx_en_i = en_new; mode_i = mode_new; en_cur = en_new;
      lim = mode_new ? HS : HF;
      len = 16 * lim;
      active = loaded && en_new;
      if (active) tag = src_multi ? "R8" : "R1 R2 R3";
      else tag = (en_new && !loaded) ? "R7" : "R6";

      nw = (f == 5 || f == 3) ? 0 : (f == 4) ? 2 : int'($urandom % 3);
      w1 = 1 + int'($urandom % (len / 2 - 1));
      w2 = len / 2 + int'($urandom % (len / 2 - 2));
      lt = ((f == 3) || ($urandom % 6 == 0)) ? len - 1 : -1;
      doclr = ($urandom % 3 == 0);
      setwin = (f % 7 == 6);
      if (doclr) flag_clr_i = 1'b1;

      for (int cyc = 0; cyc < len; cyc++) begin
        if (cyc > 0) begin wr_i = 1'b0; flag_clr_i = 1'b0; end
        if (cyc == 1) begin
          chk(irq_o == 0, "R9", irq_o, 0);
          if (doclr) chk(irq_flag_o == 0, "R10 clear", irq_flag_o, 0);
        end
        if (cyc % lim == lim / 2) begin
          logic e;
          e = active ? exp_half(pb, cyc / lim) : 1'b0;
          chk(tx_line_o == e, tag, tx_line_o, e);
        end
        if ((nw >= 1 && cyc == w1) || (nw >= 2 && cyc == w2)) begin
          wr_i = 1'b1; wdata_i = 8'($urandom);
          pm = wdata_i; pv = 1;
          if (cyc == w2) multi = 1;
        end
        if (cyc == lt) begin
          // R8: write on the boundary edge waits one more frame
          wr_i = 1'b1; wdata_i = 8'($urandom);
          late_b = wdata_i; late_v = 1;
        end
        if (setwin && cyc == len - 1) flag_clr_i = 1'b1;
        @(negedge clk);
      end
      wr_i = 1'b0; flag_clr_i = 1'b0;
      chk(irq_o == 1, en_new ? "R4" : "R5", irq_o, 1);
      if (!irq_o) wait_irq();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule